// File: doc/BRIEF.md
# Reciprocal Multi-Period Frequency Counter

This block measures the frequency of an external square wave by counting two things over one gate: whole periods of the measured signal, and ticks of a reference that runs at the system clock divided by a fixed ratio. The gate opens and closes on rising edges of the measured signal. The actual gate is therefore always a whole number of input periods, and the period count carries no ±1 error. A preset gate length in reference ticks sets the shortest gate. Once that time has elapsed, the gate stays open until the next rising edge. Downstream logic computes the frequency as reference rate × period count / tick count. The division is not part of this block.

A start strobe arms one measurement. The block waits for one full input period, counts, and then latches both counts together with a sticky wrap flag for each counter. A calibration line swaps the external input for an internal pulse train of known period. If the input goes quiet, a timeout aborts the measurement. An averager sums the results of the gates that complete within a fixed window of system clocks. It offers the two sums and the gate count on a valid/ready output.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, the latched counts, both wrap flags, `done`, `no_signal` and `avg_valid` are all 0.
- R2: After an accepted start, the first recognised rising edge only arms the measurement. Counting opens on the second rising edge.
- R3: The gate closes on the first rising edge that arrives after GATE_TICKS reference ticks have elapsed since opening. An edge in the same cycle as the last of those ticks does not close it. The period count is the number of rising edges after the opening edge, up to and including the closing edge. With an input period of P clocks, that count is floor(GATE_TICKS·DIV/P)+1, so an exact fill extends the gate by one full period.
- R4: The reference count is floor(L/DIV), where L is the gate length in system clocks. The reference divider restarts its phase on the opening edge.
- R5: `done` is high for exactly one cycle when new counts are latched. The count and flag outputs change only in that cycle and are not cleared by a start.
- R6: Each count wraps modulo 2^width. Its flag (`per_wrap`, `ref_wrap`) is 1 when that counter wrapped at least once during the gate.
- R7: While `cal_sel` is 1, the counter measures an internal pulse train with a period of CAL_DIV system clocks, and `sig_in` has no effect.
- R8: If no rising edge arrives for TIMEOUT_GATES·GATE_TICKS reference ticks while a measurement is active, the block aborts. It then raises `no_signal`, gives no `done` pulse, and holds `no_signal` until the next accepted start.
- R9: A start strobe is ignored while a measurement is active. The result and its timing are those of the first start.
- R10: The first `done` while the averager is idle opens a window of AVG_CLKS cycles. At the end of the window, `avg_per_sum`, `avg_ref_sum` and `avg_gates` carry the sums of every completed gate in it.
- R11: A published average stays valid and unchanged until it is taken (`avg_valid` and `avg_ready` high at a clock edge). Any `done` that arrives while a result is held is dropped and does not open a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous measured square wave |
| start | input | 1 | One-cycle strobe that arms a measurement when idle |
| cal_sel | input | 1 | 1 selects the internal calibration pulse train |
| per_count | output | PER_W | Latched count of input periods |
| ref_count | output | REF_W | Latched count of reference ticks |
| per_wrap | output | 1 | Period counter wrapped during the gate |
| ref_wrap | output | 1 | Reference counter wrapped during the gate |
| done | output | 1 | One-cycle pulse when new counts are latched |
| no_signal | output | 1 | The last measurement timed out with no edges |
| avg_valid | output | 1 | Averaged result is available |
| avg_ready | input | 1 | Consumer accepts the averaged result |
| avg_per_sum | output | ACC_W | Sum of period counts in the window |
| avg_ref_sum | output | ACC_W | Sum of reference counts in the window |
| avg_gates | output | GCNT_W | Number of gates summed in the window |

## Verification
The bench builds the block with a divide ratio of 2, a 20-tick preset gate, a 4-bit period counter, an 8-bit reference counter, a 10-clock calibration period, a timeout of 20 gates and a 300-cycle averaging window. With these values every gate lasts a few dozen cycles, so input periods of 8 and 20 clocks fill the preset gate exactly, like the worst-case input frequencies at full scale. They also make a 2-clock input wrap the period counter and a 600-clock input wrap the reference counter. Timeout and a two-gate averaging window each fit in under a thousand cycles.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_SYNC  = 2'd2,
    ST_COUNT = 2'd3
  } meas_st_t;
endpackage

// File: rtl/fm_sig_cond.sv
module fm_sig_cond #(
  parameter int CAL_DIV = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic cal_sel,
  output logic rise
);
  localparam int CW = (CAL_DIV > 1) ? $clog2(CAL_DIV) : 1;

  logic [CW-1:0] cal_cnt_q;
  logic          cal_q;
  logic          src;
  logic [2:0]    sync_q;

  // internal calibration train, period CAL_DIV clocks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_cnt_q <= '0;
      cal_q     <= 1'b0;
    end else begin
      cal_cnt_q <= (cal_cnt_q == CW'(CAL_DIV - 1)) ? '0 : cal_cnt_q + CW'(1);
      cal_q     <= (cal_cnt_q < CW'(CAL_DIV / 2));
    end
  end

  assign src = cal_sel ? cal_q : sig_in;

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], src};
  end

  assign rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/fm_gate_ctrl.sv
module fm_gate_ctrl
  import fm_pkg::*;
#(
  parameter int DIV           = 8,
  parameter int GATE_TICKS    = 240000,
  parameter int TIMEOUT_GATES = 4,
  parameter int PER_W         = 32,
  parameter int REF_W         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rise,
  output logic [PER_W-1:0] per_o,
  output logic [REF_W-1:0] ref_o,
  output logic             per_wrap_o,
  output logic             ref_wrap_o,
  output logic             done_o,
  output logic             nosig_o
);
  localparam int TMO_TICKS = TIMEOUT_GATES * GATE_TICKS;
  localparam int GW = $clog2(GATE_TICKS + 1);
  localparam int TW = $clog2(TMO_TICKS + 1);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  meas_st_t         st_q;
  logic [PER_W-1:0] per_cnt_q;
  logic [REF_W-1:0] ref_cnt_q;
  logic             pwrap_q, rwrap_q;
  logic [GW-1:0]    gate_q;
  logic             armed_q;
  logic [TW-1:0]    tmo_q;
  logic             tick, open, close, timeout;
  logic [PER_W-1:0] per_nxt;
  logic [REF_W-1:0] ref_nxt;
  logic             pwrap_nxt, rwrap_nxt;

  assign open    = (st_q == ST_SYNC) && rise;
  assign close   = (st_q == ST_COUNT) && rise && armed_q;
  assign timeout = (st_q != ST_IDLE) && !rise && tick && (tmo_q == TW'(TMO_TICKS - 1));

  // reference tick: clk / DIV, phase restarted on the opening edge
  generate
    if (DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || open)              div_q <= '0;
        else if (div_q == DW'(DIV - 1))  div_q <= '0;
        else                             div_q <= div_q + DW'(1);
      end
      assign tick = (div_q == DW'(DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign per_nxt   = per_cnt_q + PER_W'(1);
  assign ref_nxt   = ref_cnt_q + REF_W'(1);
  assign pwrap_nxt = pwrap_q | (&per_cnt_q);
  assign rwrap_nxt = rwrap_q | (&ref_cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      per_cnt_q  <= '0;
      ref_cnt_q  <= '0;
      pwrap_q    <= 1'b0;
      rwrap_q    <= 1'b0;
      gate_q     <= '0;
      armed_q    <= 1'b0;
      tmo_q      <= '0;
      per_o      <= '0;
      ref_o      <= '0;
      per_wrap_o <= 1'b0;
      ref_wrap_o <= 1'b0;
      done_o     <= 1'b0;
      nosig_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start) begin
          st_q    <= ST_ARM;
          nosig_o <= 1'b0;
          tmo_q   <= '0;
        end
      end else if (timeout) begin
        st_q    <= ST_IDLE;
        nosig_o <= 1'b1;
      end else begin
        if (rise)      tmo_q <= '0;
        else if (tick) tmo_q <= tmo_q + TW'(1);
        case (st_q)
          ST_ARM: if (rise) st_q <= ST_SYNC;
          ST_SYNC: if (rise) begin
            st_q      <= ST_COUNT;
            per_cnt_q <= '0;
            ref_cnt_q <= '0;
            pwrap_q   <= 1'b0;
            rwrap_q   <= 1'b0;
            gate_q    <= '0;
            armed_q   <= 1'b0;
          end
          ST_COUNT: begin
            if (tick) begin
              ref_cnt_q <= ref_nxt;
              rwrap_q   <= rwrap_nxt;
              if (!armed_q) begin
                if (gate_q == GW'(GATE_TICKS - 1)) armed_q <= 1'b1;
                else                               gate_q  <= gate_q + GW'(1);
              end
            end
            if (rise) begin
              per_cnt_q <= per_nxt;
              pwrap_q   <= pwrap_nxt;
            end
            if (close) begin
              st_q       <= ST_IDLE;
              per_o      <= per_nxt;
              per_wrap_o <= pwrap_nxt;
              ref_o      <= tick ? ref_nxt : ref_cnt_q;
              ref_wrap_o <= tick ? rwrap_nxt : rwrap_q;
              done_o     <= 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: latched results move only together with done
  p_hold_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(per_o) && $stable(ref_o)));
  // R3: a result is latched only on a rising edge after the preset gate expired
  p_close_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rise) && $past(armed_q)));
  // R8: an aborted measurement produces no done pulse
  p_nosig_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nosig_o) |-> !done_o);
endmodule

// File: rtl/fm_avg.sv
module fm_avg #(
  parameter int PER_W    = 32,
  parameter int REF_W    = 32,
  parameter int ACC_W    = 48,
  parameter int GCNT_W   = 8,
  parameter int AVG_CLKS = 90000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [REF_W-1:0]  ref_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ACC_W-1:0]  per_sum_o,
  output logic [ACC_W-1:0]  ref_sum_o,
  output logic [GCNT_W-1:0] gates_o
);
  localparam int AW = (AVG_CLKS > 1) ? $clog2(AVG_CLKS) : 1;

  logic              win_q;
  logic [AW-1:0]     wcnt_q;
  logic [ACC_W-1:0]  aper_q, aref_q, sum_per, sum_ref;
  logic [GCNT_W-1:0] ag_q, sum_g;
  logic              add;

  assign add     = done_i && !valid_o;
  assign sum_per = (win_q ? aper_q : '0) + (add ? ACC_W'(per_i) : '0);
  assign sum_ref = (win_q ? aref_q : '0) + (add ? ACC_W'(ref_i) : '0);
  assign sum_g   = (win_q ? ag_q : '0) + GCNT_W'(add);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q     <= 1'b0;
      wcnt_q    <= '0;
      aper_q    <= '0;
      aref_q    <= '0;
      ag_q      <= '0;
      valid_o   <= 1'b0;
      per_sum_o <= '0;
      ref_sum_o <= '0;
      gates_o   <= '0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (!valid_o) begin
        if (win_q || add) begin
          aper_q <= sum_per;
          aref_q <= sum_ref;
          ag_q   <= sum_g;
        end
        if (win_q) begin
          if (wcnt_q == AW'(AVG_CLKS - 1)) begin
            win_q     <= 1'b0;
            valid_o   <= 1'b1;
            per_sum_o <= sum_per;
            ref_sum_o <= sum_ref;
            gates_o   <= sum_g;
          end else begin
            wcnt_q <= wcnt_q + AW'(1);
          end
        end else if (add) begin
          win_q  <= 1'b1;
          wcnt_q <= '0;
        end
      end
    end
  end

  // R11: an offered result holds until taken
  p_stream_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(per_sum_o) && $stable(ref_sum_o) && $stable(gates_o)));
  // R10: a result appears only at the end of an open window
  p_publish_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(win_q));
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
  parameter int DIV           = 8,
  parameter int GATE_TICKS    = 240000,
  parameter int TIMEOUT_GATES = 4,
  parameter int CAL_DIV       = 150,
  parameter int PER_W         = 32,
  parameter int REF_W         = 32,
  parameter int AVG_CLKS      = 90000000,
  parameter int ACC_W         = 48,
  parameter int GCNT_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              start,
  input  logic              cal_sel,
  output logic [PER_W-1:0]  per_count,
  output logic [REF_W-1:0]  ref_count,
  output logic              per_wrap,
  output logic              ref_wrap,
  output logic              done,
  output logic              no_signal,
  output logic              avg_valid,
  input  logic              avg_ready,
  output logic [ACC_W-1:0]  avg_per_sum,
  output logic [ACC_W-1:0]  avg_ref_sum,
  output logic [GCNT_W-1:0] avg_gates
);
  logic rise;

  fm_sig_cond #(.CAL_DIV(CAL_DIV)) u_cond (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cal_sel(cal_sel), .rise(rise)
  );

  fm_gate_ctrl #(
    .DIV(DIV), .GATE_TICKS(GATE_TICKS), .TIMEOUT_GATES(TIMEOUT_GATES),
    .PER_W(PER_W), .REF_W(REF_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .start(start), .rise(rise),
    .per_o(per_count), .ref_o(ref_count), .per_wrap_o(per_wrap),
    .ref_wrap_o(ref_wrap), .done_o(done), .nosig_o(no_signal)
  );

  fm_avg #(
    .PER_W(PER_W), .REF_W(REF_W), .ACC_W(ACC_W), .GCNT_W(GCNT_W), .AVG_CLKS(AVG_CLKS)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .done_i(done), .per_i(per_count), .ref_i(ref_count),
    .valid_o(avg_valid), .ready_i(avg_ready), .per_sum_o(avg_per_sum),
    .ref_sum_o(avg_ref_sum), .gates_o(avg_gates)
  );
endmodule

// File: tb/recip_freq_meter_tb.sv
`timescale 1ns/1ps
module recip_freq_meter_tb;
  localparam int PER_W = 4, REF_W = 8, ACC_W = 16, GCNT_W = 6;

  logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0, start = 1'b0, cal_sel = 1'b0;
  logic avg_ready = 1'b1;
  logic [PER_W-1:0]  per_count;
  logic [REF_W-1:0]  ref_count;
  logic              per_wrap, ref_wrap, done, no_signal, avg_valid;
  logic [ACC_W-1:0]  avg_per_sum, avg_ref_sum;
  logic [GCNT_W-1:0] avg_gates;

  int checks = 0, failures = 0, dones = 0;
  int period_r = 10, ph = 0;
  logic gen_en = 1'b0, man_val = 1'b0;

  always #10 clk = ~clk;

  recip_freq_meter #(
    .DIV(2), .GATE_TICKS(20), .TIMEOUT_GATES(20), .CAL_DIV(10),
    .PER_W(PER_W), .REF_W(REF_W), .AVG_CLKS(300), .ACC_W(ACC_W), .GCNT_W(GCNT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start), .cal_sel(cal_sel),
    .per_count(per_count), .ref_count(ref_count), .per_wrap(per_wrap), .ref_wrap(ref_wrap),
    .done(done), .no_signal(no_signal), .avg_valid(avg_valid), .avg_ready(avg_ready),
    .avg_per_sum(avg_per_sum), .avg_ref_sum(avg_ref_sum), .avg_gates(avg_gates)
  );

  // periodic or manual input, driven on the falling edge
  always @(negedge clk) begin
    if (!gen_en) begin
      ph     <= 0;
      sig_in <= man_val;
    end else begin
      sig_in <= (ph < period_r / 2);
      ph     <= (ph + 1 >= period_r) ? 0 : ph + 1;
    end
  end

  always @(negedge clk) if (done) dones++;

  // {period, per_count, ref_count, per_wrap, ref_wrap}
  localparam int VEC [0:7][0:4] = '{
    '{10,  5, 25, 0, 0},
    '{ 7,  6, 21, 0, 0},
    '{ 8,  6, 24, 0, 0},   // exact fill of preset gate
    '{20,  3, 30, 0, 0},   // exact fill of preset gate
    '{13,  4, 26, 0, 0},
    '{ 3, 14, 21, 0, 0},
    '{ 2,  5, 21, 1, 0},   // 21 periods wrap a 4-bit counter
    '{600, 1, 44, 0, 1}    // 300 ticks wrap an 8-bit counter
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int p, input int extra, output int lat);
    period_r = p;
    gen_en = 1'b0;
    repeat (5) @(negedge clk);
    gen_en = 1'b1;
    repeat (3 * p + 5) @(negedge clk);
    start = 1'b1;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      start = (extra > 0 && lat == extra);
      if (done) break;
      if (lat > 20000) begin lat = -1; break; end
    end
    start = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL any-R watchdog act=expired exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat_a, lat_b, d0;
    logic [ACC_W-1:0] hp, hr;
    logic [GCNT_W-1:0] hg;
    bit seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(per_count == 0 && ref_count == 0, "R1 counts after reset", per_count + ref_count, 0);
    chk(!per_wrap && !ref_wrap && !done && !no_signal && !avg_valid, "R1 flags after reset",
        {per_wrap, ref_wrap, done, no_signal, avg_valid}, 0);

    // R3 R4 R6 vector table
    for (int i = 0; i < 8; i++) begin
      run(VEC[i][0], 0, lat_a);
      chk(per_count == VEC[i][1], $sformatf("R3 period count P=%0d", VEC[i][0]), per_count, VEC[i][1]);
      chk(ref_count == VEC[i][2], $sformatf("R4 ref count P=%0d", VEC[i][0]), ref_count, VEC[i][2]);
      chk(per_wrap == VEC[i][3] && ref_wrap == VEC[i][4], $sformatf("R6 wrap flags P=%0d", VEC[i][0]),
          {per_wrap, ref_wrap}, {VEC[i][3][0], VEC[i][4][0]});
      // R5 single-cycle done, results held afterwards
      @(negedge clk);
      chk(!done, "R5 done one cycle", done, 0);
      repeat (20) @(negedge clk);
      chk(per_count == VEC[i][1] && ref_count == VEC[i][2], "R5 counts held", ref_count, VEC[i][2]);
    end

    // R7 calibration train (period 10) overrides an external period of 7
    cal_sel = 1'b1;
    run(7, 0, lat_a);
    chk(per_count == 5 && ref_count == 25, "R7 calibration counts", {per_count, ref_count}, {4'd5, 8'd25});
    cal_sel = 1'b0;

    // R2 first edge only arms: lone edge, long gap, then period 10
    period_r = 10; gen_en = 1'b0; man_val = 1'b0;
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    man_val = 1'b1; repeat (3) @(negedge clk); man_val = 1'b0;
    repeat (100) @(negedge clk);
    d0 = dones;
    chk(d0 == dones && !done, "R2 no result before second edge", done, 0);
    gen_en = 1'b1;
    lat_a = 0;
    while (!done && lat_a < 5000) begin @(negedge clk); lat_a++; end
    chk(per_count == 5 && ref_count == 25, "R2 opening edge", {per_count, ref_count}, {4'd5, 8'd25});

    // R9 start during an active measurement is ignored
    run(13, 0, lat_a);
    run(13, 60, lat_b);
    chk(lat_b == lat_a, "R9 latency with extra start", lat_b, lat_a);
    chk(per_count == 4 && ref_count == 26, "R9 counts with extra start", {per_count, ref_count}, {4'd4, 8'd26});

    // R8 timeout with a silent input
    gen_en = 1'b0; man_val = 1'b0;
    repeat (5) @(negedge clk);
    d0 = dones;
    pulse_start();
    repeat (900) @(negedge clk);
    chk(no_signal, "R8 no_signal after timeout", no_signal, 1);
    chk(dones == d0, "R8 no done on abort", dones - d0, 0);
    chk(per_count == 4 && ref_count == 26, "R8 counts untouched by abort", ref_count, 26);
    run(10, 0, lat_a);
    chk(!no_signal && per_count == 5 && ref_count == 25, "R8 cleared by next start", no_signal, 0);

    // R10 two gates in one window
    repeat (400) @(negedge clk);
    avg_ready = 1'b0;
    run(10, 0, lat_a);
    run(7, 0, lat_b);
    lat_a = 0;
    while (!avg_valid && lat_a < 2000) begin @(negedge clk); lat_a++; end
    chk(avg_valid, "R10 average published", avg_valid, 1);
    chk(avg_per_sum == 11, "R10 period sum", avg_per_sum, 11);
    chk(avg_ref_sum == 46, "R10 ref sum", avg_ref_sum, 46);
    chk(avg_gates == 2, "R10 gate count", avg_gates, 2);

    // R11 back-pressure: hold, drop, then take
    hp = avg_per_sum; hr = avg_ref_sum; hg = avg_gates;
    run(13, 0, lat_a);
    repeat (5) @(negedge clk);
    chk(avg_valid && avg_per_sum == hp && avg_ref_sum == hr && avg_gates == hg,
        "R11 held under back-pressure", avg_per_sum, hp);
    avg_ready = 1'b1;
    @(negedge clk);
    avg_ready = 1'b0;
    chk(!avg_valid, "R11 released after handshake", avg_valid, 0);
    seen = 1'b0;
    repeat (400) begin @(negedge clk); if (avg_valid) seen = 1'b1; end
    chk(!seen, "R11 dropped gate opened no window", seen, 0);
    avg_ready = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule